// File: doc/BRIEF.md
# Buffered Serial Receive Port

This block takes an asynchronous serial line and turns it into a queue of bytes for a host. Each character has one start bit, eight data bits sent least significant bit first and one stop bit. There is no parity bit and no flow control. A receiver samples the synchronized line near the middle of each bit period. It pushes every well-formed byte into a first-word-fall-through queue, and it keeps two sticky error flags: one for a framing fault and one for a byte lost to a full queue.

The host side uses three simple strobes. A data read returns the byte at the head of the queue together with a valid bit and a "more waiting" bit, and removes that byte from the queue. This read never blocks. A status word shows the fill count and both flags. A control write either clears the flags and keeps the queued data, or empties the queue and clears the flags. The bit period, counted in clock cycles, and the queue depth are build-time parameters.

Top module: `serrx_port`

## Requirements
- R1: A character whose start bit is still low at its midpoint and whose stop bit samples high at its midpoint is accepted. Its eight data bits are taken least significant first, each sampled CLKS_PER_BIT cycles after the one before. The byte enters the queue through a strobe that is one clock wide.
- R2: When data_rd_i is high in cycle T, data_word_o from cycle T+1 holds the byte at the head of the queue as it was in cycle T. Bits 7:0 carry the byte, bit 8 is 1 if the queue was non-empty, and bit 9 is 1 if the queue held two or more bytes. Bits 31:10 are 0. On an empty queue, bits 9:0 are all 0.
- R3: A data read removes the head byte. A data read on an empty queue changes neither the fill count nor the order of later bytes.
- R4: status_word_o shows the state of the previous cycle. Bits 15:0 hold the fill count, saturated at 0xFFFF. Bit 16 is the overflow flag, bit 17 is the frame error flag, and bits 31:18 are 0.
- R5: The queue holds up to 2**DEPTH_LOG2 bytes and returns them in the order they arrived.
- R6: A byte that completes while the queue is full is dropped, and the overflow flag is set.
- R7: A stop bit that samples low sets the frame error flag, and that byte is dropped. A start bit that is no longer low at its midpoint also sets the frame error flag.
- R8: A control write with ctrl_i = 2'b10 clears both flags and leaves the queued bytes untouched.
- R9: A control write with ctrl_i[0] = 1 empties the queue and clears both flags.
- R10: Both flags stay set until a clearing control write or rst. While rst is high, the queue, both flags, data_word_o and status_word_o go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial line, idles high |
| data_rd_i | input | 1 | Data read strobe (pops one byte) |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_i | input | 2 | Control bits: [0] flush and clear flags, [1] clear flags only |
| data_word_o | output | 32 | Registered result of the last data read |
| status_word_o | output | 32 | Registered fill count and error flags |

## Verification
The properties assume that the line idles high when reset is released, so the first falling edge marks a real start bit. They also assume that CLKS_PER_BIT is at least 4, so the half-bit wait is a distinct count. The keep-data property assumes that no byte completes and no data read occurs in the same cycle as the clearing write. The stimulus respects this: it issues reads and control writes only while the line is idle, after each character has finished. It also breaks frames on purpose only in the frame-error and glitch cases.

// File: rtl/serrx_pkg.sv
package serrx_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  function automatic logic [15:0] sat16(input logic [31:0] v);
    return (v > 32'h0000_FFFF) ? 16'hFFFF : v[15:0];
  endfunction
endpackage

// File: rtl/serrx_sync.sv
module serrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/serrx_deser.sv
module serrx_deser
  import serrx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 868
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_i,
  output logic              byte_stb_o,
  output logic              err_stb_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int CW   = $clog2(CLKS_PER_BIT);
  localparam int HALF = CLKS_PER_BIT / 2;
  localparam logic [CW-1:0] HALF_END = CW'(HALF - 1);
  localparam logic [CW-1:0] BIT_END  = CW'(CLKS_PER_BIT - 1);

  rx_state_e         st_q;
  logic [CW-1:0]     cnt_q;
  logic [2:0]        idx_q;
  logic [BYTE_W-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= RX_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      sh_q       <= '0;
      prev_q     <= 1'b1;
      byte_stb_o <= 1'b0;
      err_stb_o  <= 1'b0;
    end else begin
      prev_q     <= rx_i;
      byte_stb_o <= 1'b0;
      err_stb_o  <= 1'b0;
      unique case (st_q)
        RX_IDLE: begin
          if (prev_q && !rx_i) begin
            st_q  <= RX_START;
            cnt_q <= '0;
          end
        end
        RX_START: begin
          if (cnt_q == HALF_END) begin
            cnt_q <= '0;
            if (!rx_i) begin
              st_q  <= RX_DATA;
              idx_q <= '0;
            end else begin
              st_q      <= RX_IDLE;
              err_stb_o <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == BIT_END) begin
            cnt_q <= '0;
            sh_q  <= {rx_i, sh_q[BYTE_W-1:1]};
            if (idx_q == 3'd7) st_q  <= RX_STOP;
            else               idx_q <= idx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == BIT_END) begin
            cnt_q <= '0;
            st_q  <= RX_IDLE;
            if (rx_i) byte_stb_o <= 1'b1;
            else      err_stb_o  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign byte_o = sh_q;
endmodule

// File: rtl/serrx_fifo.sv
module serrx_fifo #(
  parameter int DEPTH_LOG2 = 4,
  parameter int DATA_W     = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush_i,
  input  logic                push_i,
  input  logic [DATA_W-1:0]   din_i,
  input  logic                pop_i,
  output logic [DATA_W-1:0]   head_o,
  output logic [DEPTH_LOG2:0] count_o,
  output logic                full_o,
  output logic                empty_o
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [DATA_W-1:0]     mem [DEPTH];
  logic [DEPTH_LOG2-1:0] wptr_q, rptr_q;
  logic [DEPTH_LOG2:0]   cnt_q;
  logic                  wr_en, rd_en;

  assign full_o  = (cnt_q == (DEPTH_LOG2+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign wr_en   = push_i && !full_o && !flush_i;
  assign rd_en   = pop_i && !empty_o && !flush_i;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr_q] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst || flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_en) wptr_q <= wptr_q + 1'b1;
      if (rd_en) rptr_q <= rptr_q + 1'b1;
      cnt_q <= cnt_q + (DEPTH_LOG2+1)'(wr_en) - (DEPTH_LOG2+1)'(rd_en);
    end
  end

  assign head_o  = mem[rptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/serrx_port.sv
module serrx_port
  import serrx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 868,
  parameter int DEPTH_LOG2   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_i,
  input  logic              data_rd_i,
  input  logic              ctrl_wr_i,
  input  logic [1:0]        ctrl_i,
  output logic [WORD_W-1:0] data_word_o,
  output logic [WORD_W-1:0] status_word_o
);
  localparam int CNT_W = DEPTH_LOG2 + 1;

  logic              rx_s;
  logic              byte_stb, err_stb;
  logic [BYTE_W-1:0] rx_byte, head;
  logic [CNT_W-1:0]  count;
  logic              full, empty;
  logic              flush, clr_err;
  logic              ovf_q, ferr_q;
  logic [15:0]       cnt16;

  assign flush   = ctrl_wr_i && ctrl_i[0];
  assign clr_err = ctrl_wr_i && (ctrl_i[0] || ctrl_i[1]);

  serrx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d_i(rx_i), .q_o(rx_s)
  );

  serrx_deser #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_deser (
    .clk(clk), .rst(rst), .rx_i(rx_s),
    .byte_stb_o(byte_stb), .err_stb_o(err_stb), .byte_o(rx_byte)
  );

  serrx_fifo #(.DEPTH_LOG2(DEPTH_LOG2), .DATA_W(BYTE_W)) u_fifo (
    .clk(clk), .rst(rst), .flush_i(flush),
    .push_i(byte_stb), .din_i(rx_byte), .pop_i(data_rd_i),
    .head_o(head), .count_o(count), .full_o(full), .empty_o(empty)
  );

  always_ff @(posedge clk) begin
    if (rst || clr_err) begin
      ovf_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      if (byte_stb && full) ovf_q  <= 1'b1;
      if (err_stb)          ferr_q <= 1'b1;
    end
  end

  assign cnt16 = sat16(32'(count));

  always_ff @(posedge clk) begin
    if (rst) begin
      data_word_o   <= '0;
      status_word_o <= '0;
    end else begin
      status_word_o <= {14'd0, ferr_q, ovf_q, cnt16};
      if (data_rd_i) begin
        data_word_o <= {22'd0, (count > CNT_W'(1)), !empty,
                        (empty ? 8'd0 : head)};
      end
    end
  end
endmodule

// File: rtl/serrx_port_chk.sv
module serrx_port_chk #(
  parameter int DEPTH_LOG2 = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                data_rd_i,
  input logic                ctrl_wr_i,
  input logic [1:0]          ctrl_i,
  input logic [31:0]         data_word_o,
  input logic [31:0]         status_word_o,
  input logic                byte_stb,
  input logic [DEPTH_LOG2:0] count,
  input logic                ovf_q,
  input logic                ferr_q
);
  localparam int DEPTH = 1 << DEPTH_LOG2;
  logic clr;
  logic [15:0] exp_cnt;
  assign clr     = ctrl_wr_i && (ctrl_i != 2'b00);
  assign exp_cnt = (32'(count) > 32'hFFFF) ? 16'hFFFF : 16'(count);

  AST_STB_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    byte_stb |=> !byte_stb); // R1
  AST_DATA_FORMAT: assert property (@(posedge clk) disable iff (rst)
    (data_word_o[31:10] == '0) && (data_word_o[8] || data_word_o[9:0] == '0)); // R2
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (data_rd_i && count == '0 && !byte_stb && !ctrl_wr_i) |=> (count == '0)); // R3
  AST_STATUS_TRACK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_word_o[15:0] == $past(exp_cnt) &&
              status_word_o[16] == $past(ovf_q) && status_word_o[17] == $past(ferr_q))); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    32'(count) <= DEPTH); // R5
  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    (byte_stb && 32'(count) == DEPTH && !clr) |=> ovf_q); // R6
  AST_KEEP_DATA: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr_i && ctrl_i == 2'b10 && !data_rd_i && !byte_stb) |=>
    (count == $past(count) && !ovf_q && !ferr_q)); // R8
  AST_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr_i && ctrl_i[0]) |=> (count == '0 && !ovf_q && !ferr_q)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !clr) |=> ovf_q); // R10
  AST_FERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ferr_q && !clr) |=> ferr_q); // R10
endmodule

bind serrx_port serrx_port_chk #(.DEPTH_LOG2(DEPTH_LOG2)) u_chk (
  .clk(clk), .rst(rst), .data_rd_i(data_rd_i), .ctrl_wr_i(ctrl_wr_i),
  .ctrl_i(ctrl_i), .data_word_o(data_word_o), .status_word_o(status_word_o),
  .byte_stb(byte_stb), .count(count), .ovf_q(ovf_q), .ferr_q(ferr_q)
);

// File: tb/sim_serrx_port.sv
module sim_serrx_port;
  localparam int CLK_PERIOD = 10;
  localparam int CPB        = 8;
  localparam int DL2        = 2;
  localparam int DEPTH      = 1 << DL2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_i = 1'b1;
  logic        data_rd_i = 1'b0;
  logic        ctrl_wr_i = 1'b0;
  logic [1:0]  ctrl_i = 2'b00;
  logic [31:0] data_word_o, status_word_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serrx_port #(.CLKS_PER_BIT(CPB), .DEPTH_LOG2(DL2)) u0 (
    .clk(clk), .rst(rst), .rx_i(rx_i), .data_rd_i(data_rd_i),
    .ctrl_wr_i(ctrl_wr_i), .ctrl_i(ctrl_i),
    .data_word_o(data_word_o), .status_word_o(status_word_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit stop_ok);
    @(negedge clk) rx_i = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_i = b[i];
      repeat (CPB) @(negedge clk);
    end
    rx_i = stop_ok;
    repeat (CPB) @(negedge clk);
    rx_i = 1'b1;
    repeat (CPB + 2) @(negedge clk);
  endtask

  task automatic glitch();
    @(negedge clk) rx_i = 1'b0;
    repeat (3) @(negedge clk);
    rx_i = 1'b1;
    repeat (3 * CPB) @(negedge clk);
  endtask

  task automatic rd(output logic [31:0] v);
    @(negedge clk) data_rd_i = 1'b1;
    @(negedge clk) data_rd_i = 1'b0;
    v = data_word_o;
  endtask

  task automatic ctl(input logic [1:0] c);
    @(negedge clk) begin ctrl_wr_i = 1'b1; ctrl_i = c; end
    @(negedge clk) begin ctrl_wr_i = 1'b0; ctrl_i = 2'b00; end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] dword(input logic [7:0] b, input bit more);
    return {22'd0, more, 1'b1, b};
  endfunction

  function automatic logic [31:0] sword(input int cnt, input bit ovf, input bit fe);
    return {14'd0, fe, ovf, 16'(cnt)};
  endfunction

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    chk("R10 reset data", data_word_o, 32'd0);
    chk("R10 reset status", status_word_o, 32'd0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1 R2 R4: sweep every byte value
    for (int b = 0; b < 256; b++) begin
      send(8'(b), 1'b1);
      chk("R4 count one", status_word_o, sword(1, 0, 0));
      rd(v);
      chk("R1 R2 byte value", v, dword(8'(b), 1'b0));
    end

    // R3: read on empty queue
    rd(v);
    chk("R3 empty read zero", v, 32'd0);
    @(negedge clk);
    chk("R3 empty count", status_word_o, sword(0, 0, 0));

    // R5 R6: overfill by one
    for (int i = 0; i <= DEPTH; i++) send(8'(8'hA0 + i), 1'b1);
    chk("R6 full and overflow", status_word_o, sword(DEPTH, 1, 0));
    for (int i = 0; i < DEPTH; i++) begin
      rd(v);
      chk("R5 order and more bit", v, dword(8'(8'hA0 + i), i < DEPTH - 1));
    end
    rd(v);
    chk("R6 dropped byte absent", v, 32'd0);
    repeat (2) @(negedge clk);
    chk("R10 overflow sticky", status_word_o, sword(0, 1, 0));
    ctl(2'b10);
    chk("R8 clears overflow", status_word_o, sword(0, 0, 0));

    // R7 R8: stop bit low
    send(8'h11, 1'b1);
    send(8'h22, 1'b1);
    send(8'h33, 1'b0);
    chk("R7 frame error, byte dropped", status_word_o, sword(2, 0, 1));
    ctl(2'b10);
    chk("R8 keep data", status_word_o, sword(2, 0, 0));
    rd(v);
    chk("R8 data intact", v, dword(8'h11, 1'b1));

    // R7 R9: start glitch then flush
    glitch();
    chk("R7 start glitch", status_word_o, sword(1, 0, 1));
    send(8'h44, 1'b1);
    chk("R10 frame sticky", status_word_o, sword(2, 0, 1));
    ctl(2'b01);
    chk("R9 flush", status_word_o, sword(0, 0, 0));
    rd(v);
    chk("R9 flushed read", v, 32'd0);
    send(8'h5A, 1'b1);
    rd(v);
    chk("R9 queue works after flush", v, dword(8'h5A, 1'b0));

    // R10: reset while data and flags are held
    send(8'h66, 1'b1);
    glitch();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 reset clears", status_word_o, sword(0, 0, 0));
    chk("R10 reset data word", data_word_o, 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule